// File: doc/BRIEF.md
# Region Access Guard

The guard sits on the processor bus between the core and memory. It checks each request against up to eight programmable address windows and either passes the request on or stops it with a trap and a cause code. Each window has an inclusive lower bound, an inclusive upper bound, an enable bit and user-mode read, write and execute grants. Supervisor code may use any enabled window in any way. Addresses are never translated, so a permitted request leaves with the same address, kind and write data it arrived with.

The windows are set up through a 4 KB configuration aperture placed at parameter `CFG_BASE`. Only supervisor code may use the aperture. Separately, the lowest four words of memory (0x0 to 0xC) are fenced off to catch null-pointer use. The fence is lifted only while a boot flag is set. Reset sets the flag, and supervisor code clears it once through the control register. Each decision is registered and arrives together with the bus response, so a trapped request never reaches memory.

Top module: `region_guard`

## Requirements
- R1: Each request accepted in cycle N produces `respValid` in cycle N+1 and in no other cycle. In that cycle, `respTrap` is high exactly when `respCause` is nonzero.
- R2: While reset is held and after it is released, all outputs are zero, every window is disabled and the boot flag is set. An access outside the aperture therefore traps with cause 6.
- R3: Each aperture offset is a byte offset that must be a multiple of 4. Window k uses offset 16k for the lower bound, 16k+4 for the upper bound and 16k+8 for the grants. The grant bits are bit0 enable, bit1 user read, bit2 user write and bit3 user execute. A supervisor write (kind 1) takes effect for the next request. A supervisor read (kind 0, 2 or 3) returns the stored value on `respRdata`. Any other offset reads as zero.
- R4: A user-mode request to the aperture traps with cause 5 and changes no register.
- R5: Once the boot flag is clear, any request to an address in 0x0 to 0xF traps with cause 1, whatever its mode or kind. While the flag is set, these addresses get the normal window checks.
- R6: The control register is at aperture offset 0x80. A supervisor write with bit0 set clears the boot flag for good. A write with bit0 clear has no effect. A read returns the flag in bit0.
- R7: A request outside the aperture that lies in no enabled window traps with cause 6, in either mode. Both bounds of a window are included in it. A window whose enable bit is 0 matches nothing.
- R8: A user request that matches a window but lacks the grant for its kind traps. A read (kinds 0 and 3) gives cause 2, a write (kind 1) gives cause 3 and an execute (kind 2) gives cause 4. Supervisor requests need only a matching enabled window.
- R9: When enabled windows overlap, only the grants of the lowest-numbered matching window apply.
- R10: A permitted request outside the aperture raises `fwdValid` in the same cycle as its response, with address, kind and write data unchanged. Trapped requests and aperture requests never raise `fwdValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Request byte address |
| reqKind | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| reqSuper | input | 1 | Request issued in supervisor mode |
| reqWdata | input | DATA_W | Write data |
| respValid | output | 1 | Decision for the previous cycle's request |
| respTrap | output | 1 | Request was refused |
| respCause | output | 3 | Trap cause 1 to 6, 0 when permitted |
| respRdata | output | DATA_W | Aperture read data, zero otherwise |
| fwdValid | output | 1 | Permitted request forwarded to memory |
| fwdAddr | output | ADDR_W | Forwarded address |
| fwdKind | output | 2 | Forwarded kind |
| fwdWdata | output | DATA_W | Forwarded write data |

## Verification
Each piece of stored state is exposed through the very next response. A corrupted bound or grant bit changes the cause of the next request that hits that window. A stuck boot flag shows up at once as a missing or unexpected cause 1 on a low-address request. A lost aperture write shows up as a wrong `respRdata` on the following readback. The stimulus therefore places every register write right before a request or readback that depends on it. All ports are compared with the reference model on every cycle, so any mismatch is caught within one cycle of the response it corrupts.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_NULL = 3'd1,
    CAUSE_URD  = 3'd2,
    CAUSE_UWR  = 3'd3,
    CAUSE_UEX  = 3'd4,
    CAUSE_UCFG = 3'd5,
    CAUSE_MISS = 3'd6
  } cause_e;

  localparam logic [1:0] KIND_WR = 2'd1;
  localparam logic [1:0] KIND_EX = 2'd2;

  localparam int GRANT_EN = 0;
  localparam int GRANT_R  = 1;
  localparam int GRANT_W  = 2;
  localparam int GRANT_X  = 3;
  localparam int GRANT_W_BITS = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic   cfgWr;
    logic   cfgRd;
    logic   fwd;
    logic   trap;
    cause_e cause;
  } strobe_t;

endpackage

// File: rtl/region_guard_ctrl.sv
module region_guard_ctrl
  import region_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_REGIONS = 8,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'hFFFF_F000
) (
  input  logic reqValid,
  input  logic [ADDR_W-1:4] reqAddrHi,
  input  logic [1:0] reqKind,
  input  logic reqSuper,
  input  logic [NUM_REGIONS-1:0] hitVec,
  input  logic [NUM_REGIONS-1:0][GRANT_W_BITS-1:0] grantVec,
  input  logic bootActive,
  output strobe_t stb
);

  logic inCfg;
  logic isNull;
  logic found;
  logic [GRANT_W_BITS-1:0] selGrant;
  logic needGrant;
  cause_e cause;

  assign inCfg  = (reqAddrHi[ADDR_W-1:12] == CFG_BASE[ADDR_W-1:12]);
  assign isNull = (reqAddrHi == '0);

  // lowest-numbered enabled match wins
  always_comb begin
    found = 1'b0;
    selGrant = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i] && grantVec[i][GRANT_EN]) begin
        found = 1'b1;
        selGrant = grantVec[i];
      end
    end
  end

  always_comb begin
    case (reqKind)
      KIND_WR: needGrant = selGrant[GRANT_W];
      KIND_EX: needGrant = selGrant[GRANT_X];
      default: needGrant = selGrant[GRANT_R];
    endcase
  end

  always_comb begin
    cause = CAUSE_NONE;
    if (isNull && !bootActive) begin
      cause = CAUSE_NULL;
    end else if (inCfg) begin
      if (!reqSuper) cause = CAUSE_UCFG;
    end else if (!found) begin
      cause = CAUSE_MISS;
    end else if (!reqSuper && !needGrant) begin
      case (reqKind)
        KIND_WR: cause = CAUSE_UWR;
        KIND_EX: cause = CAUSE_UEX;
        default: cause = CAUSE_URD;
      endcase
    end
  end

  always_comb begin
    stb.cause = reqValid ? cause : CAUSE_NONE;
    stb.trap  = reqValid && (cause != CAUSE_NONE);
    stb.cfgWr = reqValid && (cause == CAUSE_NONE) && inCfg && (reqKind == KIND_WR);
    stb.cfgRd = reqValid && (cause == CAUSE_NONE) && inCfg && (reqKind != KIND_WR);
    stb.fwd   = reqValid && (cause == CAUSE_NONE) && !inCfg;
  end

endmodule

// File: rtl/region_guard_dp.sv
module region_guard_dp
  import region_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_REGIONS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0] reqKind,
  input  logic [DATA_W-1:0] reqWdata,
  input  strobe_t stb,
  output logic [NUM_REGIONS-1:0] hitVec,
  output logic [NUM_REGIONS-1:0][GRANT_W_BITS-1:0] grantVec,
  output logic bootActive,
  output logic respValid,
  output logic respTrap,
  output logic [2:0] respCause,
  output logic [DATA_W-1:0] respRdata,
  output logic fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [1:0] fwdKind,
  output logic [DATA_W-1:0] fwdWdata
);

  localparam logic [11:0] CTRL_OFF = 12'h080;

  logic [ADDR_W-1:0] loBound [NUM_REGIONS];
  logic [ADDR_W-1:0] hiBound [NUM_REGIONS];
  logic [11:0] offs;
  logic [2:0] slot;
  logic [1:0] field;
  logic regionSel;
  logic ctrlSel;
  logic [DATA_W-1:0] rdVal;

  assign offs  = reqAddr[11:0];
  assign slot  = offs[6:4];
  assign field = offs[3:2];
  assign ctrlSel = (offs == CTRL_OFF);
  assign regionSel = (offs[11:7] == '0) && (offs[1:0] == 2'd0) &&
                     (field != 2'd3) && (int'(slot) < NUM_REGIONS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        loBound[i]  <= '0;
        hiBound[i]  <= '0;
        grantVec[i] <= '0;
      end
    end else if (stb.cfgWr && regionSel) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (int'(slot) == i) begin
          case (field)
            2'd0:    loBound[i]  <= reqWdata[ADDR_W-1:0];
            2'd1:    hiBound[i]  <= reqWdata[ADDR_W-1:0];
            default: grantVec[i] <= reqWdata[GRANT_W_BITS-1:0];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bootActive <= 1'b1;
    else if (stb.cfgWr && ctrlSel && reqWdata[0]) bootActive <= 1'b0;
  end

  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
      assign hitVec[g] = (reqAddr >= loBound[g]) && (reqAddr <= hiBound[g]);
    end
  endgenerate

  always_comb begin
    rdVal = '0;
    if (ctrlSel) begin
      rdVal[0] = bootActive;
    end else if (regionSel) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (int'(slot) == i) begin
          case (field)
            2'd0:    rdVal[ADDR_W-1:0] = loBound[i];
            2'd1:    rdVal[ADDR_W-1:0] = hiBound[i];
            default: rdVal[GRANT_W_BITS-1:0] = grantVec[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respTrap  <= 1'b0;
      respCause <= '0;
      respRdata <= '0;
      fwdValid  <= 1'b0;
      fwdAddr   <= '0;
      fwdKind   <= '0;
      fwdWdata  <= '0;
    end else begin
      respValid <= reqValid;
      respTrap  <= stb.trap;
      respCause <= stb.cause;
      respRdata <= stb.cfgRd ? rdVal : '0;
      fwdValid  <= stb.fwd;
      if (reqValid) begin
        fwdAddr  <= reqAddr;
        fwdKind  <= reqKind;
        fwdWdata <= reqWdata;
      end
    end
  end

endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_REGIONS = 8,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'hFFFF_F000
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0] reqKind,
  input  logic reqSuper,
  input  logic [DATA_W-1:0] reqWdata,
  output logic respValid,
  output logic respTrap,
  output logic [2:0] respCause,
  output logic [DATA_W-1:0] respRdata,
  output logic fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [1:0] fwdKind,
  output logic [DATA_W-1:0] fwdWdata
);

  strobe_t stb;
  logic [NUM_REGIONS-1:0] hitVec;
  logic [NUM_REGIONS-1:0][GRANT_W_BITS-1:0] grantVec;
  logic bootActive;

  region_guard_ctrl #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .CFG_BASE(CFG_BASE)
  ) u_ctrl (
    .reqValid(reqValid), .reqAddrHi(reqAddr[ADDR_W-1:4]), .reqKind(reqKind),
    .reqSuper(reqSuper), .hitVec(hitVec), .grantVec(grantVec),
    .bootActive(bootActive), .stb(stb)
  );

  region_guard_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGIONS(NUM_REGIONS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqWdata(reqWdata), .stb(stb),
    .hitVec(hitVec), .grantVec(grantVec), .bootActive(bootActive),
    .respValid(respValid), .respTrap(respTrap), .respCause(respCause),
    .respRdata(respRdata), .fwdValid(fwdValid), .fwdAddr(fwdAddr),
    .fwdKind(fwdKind), .fwdWdata(fwdWdata)
  );

endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'hFFFF_F000
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0] reqKind,
  input logic reqSuper,
  input logic respValid,
  input logic respTrap,
  input logic [2:0] respCause,
  input logic fwdValid,
  input logic [ADDR_W-1:0] fwdAddr,
  input logic [1:0] fwdKind,
  input logic bootActive
);

  logic inAperture;
  logic lowWords;
  assign inAperture = (reqAddr[ADDR_W-1:12] == CFG_BASE[ADDR_W-1:12]);
  assign lowWords   = (reqAddr[ADDR_W-1:4] == '0);

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!respValid && !fwdValid)); // R1
  AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    respTrap |-> (respValid && respCause != 3'd0)); // R1
  AST_USER_APERTURE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqSuper && inAperture) |=> (respTrap && respCause == 3'd5)); // R4
  AST_NULL_FENCE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lowWords && !bootActive) |=> (respCause == 3'd1)); // R5
  AST_BOOT_ONE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    !bootActive |=> !bootActive); // R6
  AST_NO_FWD_ON_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    respTrap |-> !fwdValid); // R10
  AST_FWD_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (fwdAddr == $past(reqAddr) && fwdKind == $past(reqKind))); // R10

endmodule

bind region_guard region_guard_chk #(.ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqKind(reqKind), .reqSuper(reqSuper), .respValid(respValid),
  .respTrap(respTrap), .respCause(respCause), .fwdValid(fwdValid),
  .fwdAddr(fwdAddr), .fwdKind(fwdKind), .bootActive(bootActive)
);

// File: tb/region_guard_bench.sv
module region_guard_bench;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NREG = 8;
  localparam logic [31:0] AP = 32'hFFFF_F000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0] reqKind = '0;
  logic reqSuper = 1'b0;
  logic [31:0] reqWdata = '0;
  logic respValid, respTrap, fwdValid;
  logic [2:0] respCause;
  logic [31:0] respRdata, fwdAddr, fwdWdata;
  logic [1:0] fwdKind;

  region_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGIONS(NREG), .CFG_BASE(AP))
  u_region_guard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqSuper(reqSuper), .reqWdata(reqWdata),
    .respValid(respValid), .respTrap(respTrap), .respCause(respCause),
    .respRdata(respRdata), .fwdValid(fwdValid), .fwdAddr(fwdAddr),
    .fwdKind(fwdKind), .fwdWdata(fwdWdata)
  );

  always #4 clk = ~clk;

  // reference state
  logic [31:0] mLo [NREG];
  logic [31:0] mHi [NREG];
  logic [3:0]  mGrant [NREG];
  bit mBoot;
  bit armed = 0;
  string curTag = "R2";
  string eTag = "R2";
  logic eValid, eTrap, eFwd;
  logic [2:0] eCause;
  logic [31:0] eRdata, eAddr, eWdata;
  logic [1:0] eKind;
  int vectors = 0;
  int miscompares = 0;

  always @(posedge clk) begin
    armed = 1;
    eTag = curTag;
    eValid = 0; eTrap = 0; eFwd = 0; eCause = 0; eRdata = 0;
    if (!rstN) begin
      mBoot = 1;
      for (int i = 0; i < NREG; i++) begin mLo[i] = 0; mHi[i] = 0; mGrant[i] = 0; end
    end else if (reqValid) begin
      int hit;
      bit inAp;
      logic [11:0] off;
      inAp = (reqAddr[31:12] == AP[31:12]);
      off = reqAddr[11:0];
      hit = -1;
      if (reqAddr < 32'h10 && !mBoot) eCause = 1;
      else if (inAp) begin
        if (!reqSuper) eCause = 5;
      end else begin
        for (int i = 0; i < NREG; i++)
          if (hit < 0 && mGrant[i][0] && reqAddr >= mLo[i] && reqAddr <= mHi[i]) hit = i;
        if (hit < 0) eCause = 6;
        else if (!reqSuper) begin
          if (reqKind == 2 && !mGrant[hit][3]) eCause = 4;
          else if (reqKind == 1 && !mGrant[hit][2]) eCause = 3;
          else if ((reqKind == 0 || reqKind == 3) && !mGrant[hit][1]) eCause = 2;
        end
      end
      eValid = 1;
      eTrap = (eCause != 0);
      eFwd = (eCause == 0) && !inAp;
      eAddr = reqAddr; eKind = reqKind; eWdata = reqWdata;
      if (eCause == 0 && inAp) begin
        if (reqKind == 1) begin
          if (off == 12'h080) begin
            if (reqWdata[0]) mBoot = 0;
          end else if (off < 12'h080 && off[1:0] == 0) begin
            case (off[3:2])
              2'd0: mLo[off[6:4]] = reqWdata;
              2'd1: mHi[off[6:4]] = reqWdata;
              2'd2: mGrant[off[6:4]] = reqWdata[3:0];
              default: ;
            endcase
          end
        end else begin
          if (off == 12'h080) eRdata = {31'd0, mBoot};
          else if (off < 12'h080 && off[1:0] == 0) begin
            case (off[3:2])
              2'd0: eRdata = mLo[off[6:4]];
              2'd1: eRdata = mHi[off[6:4]];
              2'd2: eRdata = {28'd0, mGrant[off[6:4]]};
              default: eRdata = 0;
            endcase
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      vectors++;
      if (respValid !== eValid) begin miscompares++;
        $display("FAIL %s respValid got %0b exp %0b", eTag, respValid, eValid); end
      if (respTrap !== eTrap) begin miscompares++;
        $display("FAIL %s respTrap got %0b exp %0b", eTag, respTrap, eTrap); end
      if (respCause !== eCause) begin miscompares++;
        $display("FAIL %s respCause got %0d exp %0d", eTag, respCause, eCause); end
      if (respRdata !== eRdata) begin miscompares++;
        $display("FAIL %s respRdata got %h exp %h", eTag, respRdata, eRdata); end
      if (fwdValid !== eFwd) begin miscompares++;
        $display("FAIL %s fwdValid got %0b exp %0b", eTag, fwdValid, eFwd); end
      if (eFwd && (fwdAddr !== eAddr || fwdKind !== eKind || fwdWdata !== eWdata)) begin
        miscompares++;
        $display("FAIL %s fwd fields got %h/%0d/%h exp %h/%0d/%h", eTag,
                 fwdAddr, fwdKind, fwdWdata, eAddr, eKind, eWdata);
      end
    end
  end

  task automatic req(input logic [31:0] a, input logic [1:0] k, input logic s,
                     input logic [31:0] d, input string t);
    @(posedge clk); #1;
    reqValid = 1; reqAddr = a; reqKind = k; reqSuper = s; reqWdata = d; curTag = t;
  endtask

  task automatic idle(input int n, input string t);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      reqValid = 0; curTag = t;
    end
  endtask

  bit finished = 0;

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle(3, "R2");
    @(posedge clk); #1; rstN = 1;
    idle(1, "R2");
    req(32'h0000_1000, 0, 0, 0, "R2");           // nothing enabled -> 6
    req(32'h0000_0004, 0, 1, 0, "R5");           // boot waives fence, still miss -> 6
    // R3: window programming
    req(AP + 32'h00, 1, 1, 32'h0000_0000, "R3");
    req(AP + 32'h04, 1, 1, 32'h0000_0FFF, "R3");
    req(AP + 32'h08, 1, 1, 32'h0000_000F, "R3");
    req(AP + 32'h10, 1, 1, 32'h0000_1000, "R3");
    req(AP + 32'h14, 1, 1, 32'h0000_1FFF, "R3");
    req(AP + 32'h18, 1, 1, 32'h0000_0003, "R3");
    req(AP + 32'h20, 1, 1, 32'h0000_1800, "R3");
    req(AP + 32'h24, 1, 1, 32'h0000_2FFF, "R3");
    req(AP + 32'h28, 1, 1, 32'h0000_000F, "R3");
    req(AP + 32'h30, 1, 1, 32'h0000_3000, "R3");
    req(AP + 32'h34, 1, 1, 32'h0000_30FF, "R3");
    req(AP + 32'h38, 1, 1, 32'h0000_0001, "R3");
    req(AP + 32'h14, 0, 1, 0, "R3");
    req(AP + 32'h38, 2, 1, 0, "R3");
    req(AP + 32'h3C, 0, 1, 0, "R3");             // unused offset reads zero
    req(32'h0000_0004, 0, 0, 0, "R5");           // boot set: window 0 grants
    // R8
    req(32'h0000_1004, 1, 0, 32'hA5A5_0001, "R8");
    req(32'h0000_1004, 2, 0, 0, "R8");
    req(32'h0000_1004, 0, 0, 0, "R8");
    req(32'h0000_3000, 0, 0, 0, "R8");
    req(32'h0000_3000, 1, 1, 32'h1234_5678, "R8");
    req(32'h0000_3080, 2, 1, 0, "R8");
    // R9
    req(32'h0000_1800, 1, 0, 32'hDEAD_BEEF, "R9");
    req(32'h0000_2000, 1, 0, 32'hCAFE_0002, "R9");
    req(32'h0000_1FFF, 2, 0, 0, "R9");
    // R7
    req(32'h0000_2FFF, 0, 0, 0, "R7");
    req(32'h0000_3100, 0, 1, 0, "R7");
    req(32'h0000_30FF, 1, 1, 32'h0BAD_F00D, "R7");
    req(32'h8000_0000, 0, 1, 0, "R7");
    idle(2, "R1");
    // R4
    req(AP + 32'h38, 1, 0, 32'h0000_000F, "R4");
    req(AP + 32'h38, 0, 1, 0, "R4");
    req(AP + 32'h80, 1, 0, 32'h0000_0001, "R4");
    req(AP + 32'h80, 0, 1, 0, "R4");
    // R6
    req(AP + 32'h80, 1, 1, 32'h0000_0000, "R6");
    req(AP + 32'h80, 0, 1, 0, "R6");
    req(AP + 32'h80, 1, 1, 32'h0000_0001, "R6");
    req(AP + 32'h80, 3, 1, 0, "R6");
    // R5
    req(32'h0000_000C, 0, 0, 0, "R5");
    req(32'h0000_0000, 2, 1, 0, "R5");
    req(32'h0000_0008, 1, 1, 32'h1111_2222, "R5");
    req(32'h0000_0010, 0, 0, 0, "R5");
    // R10 and kind 3
    req(32'h0000_0100, 3, 0, 0, "R10");
    req(32'h0000_1100, 3, 0, 0, "R10");
    req(32'h0000_0200, 1, 0, 32'h7777_8888, "R10");
    req(32'h0000_3010, 3, 0, 0, "R10");
    // R7: disabling window 2
    req(AP + 32'h28, 1, 1, 32'h0000_0000, "R7");
    req(32'h0000_2000, 1, 0, 32'h1, "R7");
    req(32'h0000_1800, 0, 1, 0, "R7");
    idle(3, "R1");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule